// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a periodic event generator that sits on a simple byte-wide, synchronous CPU bus. It has a window of four byte registers. One byte holds control and three bytes hold a 24-bit interval. While the timer runs, an internal counter steps up once per clock. When the next step would reach the programmed interval, the block emits an interrupt event and the counter restarts from zero. The interval therefore sets the event period, measured in clock cycles.

A control bit picks where each event goes: the maskable request output or the non-maskable request output. Software reads the control byte back at offset 0. The three interval offsets do not read back the interval. They return the live counter, one byte per offset. Software can therefore watch the count without a separate capture register.

Bus transfers take effect on the clock edge at which the chip-select is high. Read data is registered and appears in the cycle after the request. In any cycle that follows a cycle with no read request, the read data is zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, the enable flag, the route flag, the interval and the counter are all zero. Every offset reads zero and neither interrupt output is high.
- R2: A read of offset 0 returns the enable flag in bit 0 and the route (non-maskable) flag in bit 1. Bits 7..2 read zero. Read data shows up one cycle after the request and is zero in a cycle that follows no read request.
- R3: Reads of offsets 1, 2 and 3 return the counter's bits 7..0, 15..8 and 23..16. The value returned is the count held just before the edge that takes the request.
- R4: A write to offset 1, 2 or 3 replaces interval bits 7..0, 15..8 or 23..16 respectively. The other two interval bytes are left as they were.
- R5: The counter holds its value unless the timer is enabled and the interval is nonzero. Under those two conditions it advances by one per clock.
- R6: When the count plus one equals the interval, the counter goes to zero on that edge and an event is raised. Events therefore occur every interval cycles, starting from the edge that enabled the timer.
- R7: An event drives a one-cycle high pulse in the cycle after the terminal edge. The pulse goes on nmi_o when control bit 1 is set and on irq_o when it is clear, never on both.
- R8: A control write that sets enable while the timer is disabled clears the counter. A control write that sets enable while the timer is already enabled does not clear it. Clearing enable freezes the counter at its current value.
- R9: A bus cycle with cs_i low has no effect on any register, even when we_i is high. Its read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip-select for a bus transfer |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset within the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Maskable interrupt request pulse |
| nmi_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
The bench times the gap from the enabling write to the first pulse, and the gap between consecutive pulses. An off-by-one compare would make either gap one cycle long or short. A design that clears the counter on every enable write would show a re-enabled count restarting at zero instead of carrying on. One that clears the counter on disable would lose the frozen value. The bench also rewrites one interval byte and measures the new period; a design whose byte writes spill into the wrong byte gets a different period or stops counting. The bench reads counter bytes across the 0xFF to 0x100 carry, checks that the route bit moves the pulse between outputs, and issues writes with chip-select low, which must leave the control byte unchanged.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam int CTRL_OFFSET  = 0;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_NMI_BIT = 1;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 2,
    parameter int CNT_W     = DATA_W * NUM_BYTES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              en_o,
    output logic              nmi_sel_o,
    output logic [CNT_W-1:0]  interval_o,
    output logic              start_o
);
    typedef struct packed {
        logic             en;
        logic             nmi_sel;
        logic [CNT_W-1:0] interval;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr;

    assign ctrl_wr = wr_i && (addr_i == ADDR_W'(CTRL_OFFSET));

    always_comb begin
        regs_d = regs_q;
        if (ctrl_wr) begin
            regs_d.en      = wdata_i[CTRL_EN_BIT];
            regs_d.nmi_sel = wdata_i[CTRL_NMI_BIT];
        end
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (wr_i && (addr_i == ADDR_W'(b + 1))) begin
                regs_d.interval[b*DATA_W +: DATA_W] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign start_o    = ctrl_wr && wdata_i[CTRL_EN_BIT] && !regs_q.en;
    assign en_o       = regs_q.en;
    assign nmi_sel_o  = regs_q.nmi_sel;
    assign interval_o = regs_q.interval;
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic             running;
    logic [CNT_W-1:0] next_count;

    assign running    = en_i && (interval_i != '0);
    assign next_count = cnt_q.count + CNT_W'(1);
    assign hit_o      = running && (next_count == interval_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d.count = '0;
        end else if (running) begin
            cnt_d.count = hit_o ? '0 : next_count;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;
endmodule

// File: rtl/tick_timer_route.sv
module tick_timer_route (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic nmi_sel_i,
    output logic irq_o,
    output logic nmi_o
);
    typedef struct packed {
        logic irq;
        logic nmi;
    } route_t;

    route_t route_d, route_q;

    always_comb begin
        route_d.irq = hit_i && !nmi_sel_i;
        route_d.nmi = hit_i && nmi_sel_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign irq_o = route_q.irq;
    assign nmi_o = route_q.nmi;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 3
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cs_i,
    input  logic        we_i,
    input  logic [1:0]  addr_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        irq_o,
    output logic        nmi_o
);
    localparam int CNT_W  = DATA_W * NUM_BYTES;
    localparam int ADDR_W = $clog2(NUM_BYTES + 1);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } bus_t;

    bus_t              bus_d, bus_q;
    logic              en;
    logic              nmi_sel;
    logic              start;
    logic              hit;
    logic [CNT_W-1:0]  interval;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] cnt_bytes [NUM_BYTES];
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] ctrl_view;

    assign addr  = ADDR_W'(addr_i);
    assign wdata = DATA_W'(wdata_i);

    tick_timer_regs #(
        .DATA_W   (DATA_W),
        .NUM_BYTES(NUM_BYTES),
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cs_i && we_i),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .en_o      (en),
        .nmi_sel_o (nmi_sel),
        .interval_o(interval),
        .start_o   (start)
    );

    tick_timer_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en),
        .clear_i   (start),
        .interval_i(interval),
        .count_o   (count),
        .hit_o     (hit)
    );

    tick_timer_route u_route (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_i    (hit),
        .nmi_sel_i(nmi_sel),
        .irq_o    (irq_o),
        .nmi_o    (nmi_o)
    );

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign cnt_bytes[g] = count[g*DATA_W +: DATA_W];
    end

    always_comb begin
        ctrl_view               = '0;
        ctrl_view[CTRL_EN_BIT]  = en;
        ctrl_view[CTRL_NMI_BIT] = nmi_sel;
    end

    always_comb begin
        bus_d.rdata = '0;
        if (cs_i && !we_i) begin
            if (addr == ADDR_W'(CTRL_OFFSET)) begin
                bus_d.rdata = ctrl_view;
            end
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (addr == ADDR_W'(b + 1)) begin
                    bus_d.rdata = cnt_bytes[b];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rdata_o = 8'(bus_q.rdata);
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic             nmi_o,
    input logic             en,
    input logic             nmi_sel,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] interval
);
    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_o && nmi_o));

    a_r7_irq_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !$past(nmi_sel));

    a_r7_nmi_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nmi_o |-> $past(nmi_sel));

    a_r6_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o || nmi_o) |-> (count == '0));

    a_r6_event_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o || nmi_o) |-> ($past(en) && ($past(interval) != '0)));

    a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (count == '0));

    a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((!en || (interval == '0)) && !start) |=> $stable(count));
endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_o   (irq_o),
    .nmi_o   (nmi_o),
    .en      (en),
    .nmi_sel (nmi_sel),
    .start   (start),
    .count   (count),
    .interval(interval)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cs_i = 1'b0;
    logic       we_i = 1'b0;
    logic [1:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;
    logic       nmi_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  rd_seen = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    tick_timer uut (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cs_i   (cs_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .rdata_o(rdata_o),
        .irq_o  (irq_o),
        .nmi_o  (nmi_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // monitor: pops expected read data one cycle after each read request
    always @(posedge clk_i) rd_seen <= cs_i && !we_i && rst_ni;

    always @(negedge clk_i) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard underflow", int'(rdata_o), -1);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata_o == e, t, int'(rdata_o), int'(e));
            end
        end
    end

    // driver tasks: called at a negedge, return at the next negedge
    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        cs_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        cs_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, logic [7:0] expv, string tag);
        cs_i = 1'b1; we_i = 1'b0; addr_i = a;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk_i);
        cs_i = 1'b0;
    endtask

    task automatic idle(int n);
        cs_i = 1'b0; we_i = 1'b0;
        repeat (n) @(negedge clk_i);
    endtask

    task automatic wait_pulse(int expv, bit want_nmi, bit from_pulse, string tag);
        int k = 0;
        if (from_pulse) begin
            @(negedge clk_i);
            k = 1;
            check(!irq_o && !nmi_o, {tag, " R7 pulse one cycle"},
                  int'(irq_o | nmi_o), 0);
        end
        while (!(irq_o || nmi_o) && k < 5000) begin
            @(negedge clk_i);
            k++;
        end
        check(k == expv, {tag, " R6 period"}, k, expv);
        check(nmi_o == want_nmi && irq_o == !want_nmi, {tag, " R7 route"},
              int'({nmi_o, irq_o}), want_nmi ? 2 : 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        check(!irq_o && !nmi_o, "R1 outputs quiet", int'({nmi_o, irq_o}), 0);
        bus_read(2'd0, 8'h00, "R1 ctrl after reset");
        bus_read(2'd1, 8'h00, "R1 count lo after reset");
        bus_read(2'd2, 8'h00, "R1 count mid after reset");
        bus_read(2'd3, 8'h00, "R1 count hi after reset");

        // R5 zero interval: enabled but no counting
        bus_write(2'd0, 8'h01);
        idle(4);
        bus_read(2'd1, 8'h00, "R5 no count with zero interval");
        bus_read(2'd0, 8'h01, "R2 ctrl enable bit");
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, 8'h03, "R2 ctrl upper bits zero");
        bus_write(2'd0, 8'h00);

        // R9 write with cs low ignored
        cs_i = 1'b0; we_i = 1'b1; addr_i = 2'd0; wdata_i = 8'h03;
        @(negedge clk_i);
        we_i = 1'b0;
        bus_read(2'd0, 8'h00, "R9 cs low write ignored");
        idle(1);
        check(rdata_o == 8'h00, "R2 R9 rdata zero without read", int'(rdata_o), 0);

        // R6 R7 interval 5 on irq
        bus_write(2'd1, 8'd5);
        bus_write(2'd2, 8'd0);
        bus_write(2'd3, 8'd0);
        bus_write(2'd0, 8'h01);
        wait_pulse(5, 1'b0, 1'b0, "irq first");
        wait_pulse(5, 1'b0, 1'b1, "irq second");

        // R3 R6 live counter reads with wrap
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h01);
        for (int i = 0; i < 7; i++) begin
            bus_read(2'd1, 8'(i % 5), "R3 R6 count sequence");
        end

        // R8 disable freezes, enable from disabled clears, re-enable keeps
        bus_write(2'd0, 8'h00);
        idle(3);
        bus_read(2'd1, 8'd3, "R8 count frozen when disabled");
        bus_write(2'd0, 8'h01);
        bus_read(2'd1, 8'd0, "R8 enable clears count");
        bus_write(2'd0, 8'h01);
        bus_read(2'd1, 8'd2, "R8 re-enable keeps count");

        // R3 R4 multi-byte interval 0x000102, nmi route
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h02);
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, 8'h03);
        idle(256);
        bus_read(2'd1, 8'h00, "R3 count lo byte past carry");
        bus_read(2'd2, 8'h01, "R3 count mid byte");
        bus_read(2'd3, 8'h00, "R3 count hi byte");
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h03);
        wait_pulse(258, 1'b1, 1'b0, "R4 nmi interval 258");

        // R4 single-byte rewrite leaves others intact
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h04);
        bus_write(2'd3, 8'h00);
        bus_write(2'd0, 8'h03);
        wait_pulse(260, 1'b1, 1'b0, "R4 low byte rewrite");
        wait_pulse(260, 1'b1, 1'b1, "R4 nmi second");

        idle(2);
        check(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule